// File: doc/BRIEF.md
# Synthesizer Divider and Phase-Frequency Detector Core

This block is the digital front end of a frequency synthesizer loop. Running on a fast sampling clock, it samples a logic-level RF feedback signal and a reference signal. It divides the feedback by a ratio chosen on two static select pins and divides the reference by a fixed two. It then compares the two divided signals in a tri-state phase-frequency detector. The detector produces pump-up and pump-down commands for an external charge pump. Whenever both commands are active together, they are held for a fixed overlap of sampling-clock cycles before both clear, so the transfer function has no dead zone.

Two static mode pins decode jointly into three settings. The first is whether the pump drivers are enabled; when they are not, the loop is open. The second is whether the detector polarity is inverted, which suits a VCO with a negative tuning slope. The third is what the monitor pin shows: a constant high, the divided reference, the divided feedback, or a constant low. The integrator must pick a feedback ratio that keeps the divided feedback at or below the highest rate the detector can compare.

Top module: `pfd_divider_core`

## Requirements
- R1: The feedback ratio follows `div_sel`: 2'b00 divides by 8, 2'b01 by 16, 2'b10 by 32 and 2'b11 by 64. Each divider output is a square wave that toggles once every ratio/2 rising edges of `rf_in`.
- R2: The reference path always divides `ref_in` by exactly 2, so its output toggles on every rising edge of `ref_in`.
- R3: A change of `div_sel` does not affect the division period already in progress. It takes effect from the next terminal count of the feedback divider.
- R4: `pump_oe` is low only when `mode_sel` is 2'b01. It is high in the other three modes.
- R5: `mon_out` shows the following for each value of `mode_sel`: 2'b00 gives constant high, 2'b01 gives the divided reference, 2'b10 gives the divided feedback, and 2'b11 gives constant low.
- R6: A rising edge of the divided reference sets the up flag, and a rising edge of the divided feedback sets the down flag. A flag that is set alone stays set until the other flag is also set.
- R7: Once both flags are set, both stay set for exactly ABL_CYC sampling-clock cycles (default 3) and then clear together.
- R8: In mode 2'b11 the detector polarity is inverted: the up flag drives `pump_dn` and the down flag drives `pump_up`. In all other modes the up flag drives `pump_up`.
- R9: While `pump_oe` is low, `pump_up` and `pump_dn` are held low, but the detector flags keep updating. A flag set during that time appears at the outputs as soon as the drivers are enabled again.
- R10: A synchronous active-high `rst` clears both divider counters and outputs, both detector flags and the overlap counter. After reset `pump_up` and `pump_dn` are low and both divided signals are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_in | input | 1 | Logic-level RF feedback signal |
| ref_in | input | 1 | Reference signal |
| div_sel | input | 2 | Feedback ratio select |
| mode_sel | input | 2 | Pump enable, polarity and monitor select |
| pump_up | output | 1 | Charge-pump up command |
| pump_dn | output | 1 | Charge-pump down command |
| pump_oe | output | 1 | Pump driver enable (low = tri-state) |
| mon_out | output | 1 | Monitor output |

## Verification
Free-running square waves on `rf_in` for every select value, and on `ref_in`, are measured as monitor periods. These periods separate the four feedback ratios from one another and from the fixed reference ratio. Counted single pulses, with `div_sel` changed part of the way through a division, show whether the new ratio waits for the terminal count. Single divided-reference and divided-feedback edges, applied in both orders and followed by the other edge, separate a held one-sided flag from the fixed-length overlap. Repeating that sequence in the inverted mode and in the open-loop mode separates the role swap from the output gating, and also shows that the flag state is kept while the outputs are gated.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        MON_HIGH = 2'b00,
        MON_REF  = 2'b01,
        MON_FB   = 2'b10,
        MON_LOW  = 2'b11
    } mon_src_e;

    typedef struct packed {
        logic     drive_en;
        logic     invert;
        mon_src_e mon;
    } mode_cfg_t;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_t;

    // Joint decode of the two static mode pins.
    function automatic mode_cfg_t decode_mode(input logic [1:0] m);
        mode_cfg_t c;
        case (m)
            2'b00:   c = '{drive_en: 1'b1, invert: 1'b0, mon: MON_HIGH};
            2'b01:   c = '{drive_en: 1'b0, invert: 1'b0, mon: MON_REF};
            2'b10:   c = '{drive_en: 1'b1, invert: 1'b0, mon: MON_FB};
            default: c = '{drive_en: 1'b1, invert: 1'b1, mon: MON_LOW};
        endcase
        return c;
    endfunction

    // Half of the feedback ratio: 2^(base_log2 + sel) / 2.
    function automatic int unsigned fb_half(input int unsigned base_log2, input logic [1:0] sel);
        return 32'd1 << (base_log2 - 1 + int'(sel));
    endfunction

endpackage

// File: rtl/edge_rise.sv
module edge_rise #(
    parameter bit PRE_SYNC = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic rise
);
    logic d_s;
    logic d_q;

    generate
        if (PRE_SYNC) begin : g_sync
            logic d_r;
            always_ff @(posedge clk) begin
                if (rst) d_r <= 1'b0;
                else     d_r <= d;
            end
            assign d_s = d_r;
        end else begin : g_direct
            assign d_s = d;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) d_q <= 1'b0;
        else     d_q <= d_s;
    end

    assign rise = d_s & ~d_q;
endmodule

// File: rtl/toggle_divider.sv
module toggle_divider #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] half_in,
    output logic             div_o
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_act;
    logic             term;

    assign term = (cnt == half_act - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            half_act <= half_in;
            div_o    <= 1'b0;
        end else if (tick) begin
            if (term) begin
                cnt      <= '0;
                div_o    <= ~div_o;
                half_act <= half_in;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
#(
    parameter int ABL_CYC = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  ref_div,
    input  logic  fb_div,
    output pump_t flags
);
    localparam int AW = $clog2(ABL_CYC + 1);

    logic          ref_rise;
    logic          fb_rise;
    logic [AW-1:0] ovl_cnt;
    logic          both;
    logic          clr;

    edge_rise #(.PRE_SYNC(1'b0)) u_ref_edge (.clk(clk), .rst(rst), .d(ref_div), .rise(ref_rise));
    edge_rise #(.PRE_SYNC(1'b0)) u_fb_edge  (.clk(clk), .rst(rst), .d(fb_div),  .rise(fb_rise));

    assign both = flags.up & flags.dn;
    assign clr  = both && (ovl_cnt == AW'(ABL_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            ovl_cnt <= '0;
        end else begin
            flags.up <= (flags.up & ~clr) | ref_rise;
            flags.dn <= (flags.dn & ~clr) | fb_rise;
            if (both && !clr) ovl_cnt <= ovl_cnt + 1'b1;
            else              ovl_cnt <= '0;
        end
    end
endmodule

// File: rtl/pfd_divider_core.sv
module pfd_divider_core
    import pfd_pkg::*;
#(
    parameter int FB_BASE_LOG2 = 3,
    parameter int ABL_CYC      = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rf_in,
    input  logic       ref_in,
    input  logic [1:0] div_sel,
    input  logic [1:0] mode_sel,
    output logic       pump_up,
    output logic       pump_dn,
    output logic       pump_oe,
    output logic       mon_out
);
    localparam int FB_CW = FB_BASE_LOG2 + 3;

    logic             rf_rise;
    logic             ref_rise;
    logic             fb_div;
    logic             ref_div;
    logic [FB_CW-1:0] fb_half_v;
    pump_t            flags;
    mode_cfg_t        cfg;

    edge_rise #(.PRE_SYNC(1'b1)) u_rf_edge  (.clk(clk), .rst(rst), .d(rf_in),  .rise(rf_rise));
    edge_rise #(.PRE_SYNC(1'b1)) u_ref_edge (.clk(clk), .rst(rst), .d(ref_in), .rise(ref_rise));

    assign fb_half_v = FB_CW'(fb_half(FB_BASE_LOG2, div_sel));

    toggle_divider #(.CNT_W(FB_CW)) u_fb_div (
        .clk(clk), .rst(rst), .tick(rf_rise), .half_in(fb_half_v), .div_o(fb_div)
    );

    toggle_divider #(.CNT_W(1)) u_ref_div (
        .clk(clk), .rst(rst), .tick(ref_rise), .half_in(1'b1), .div_o(ref_div)
    );

    pfd_core #(.ABL_CYC(ABL_CYC)) u_pfd (
        .clk(clk), .rst(rst), .ref_div(ref_div), .fb_div(fb_div), .flags(flags)
    );

    assign cfg     = decode_mode(mode_sel);
    assign pump_oe = cfg.drive_en;
    assign pump_up = cfg.drive_en & (cfg.invert ? flags.dn : flags.up);
    assign pump_dn = cfg.drive_en & (cfg.invert ? flags.up : flags.dn);

    always_comb begin
        case (cfg.mon)
            MON_HIGH: mon_out = 1'b1;
            MON_REF:  mon_out = ref_div;
            MON_FB:   mon_out = fb_div;
            default:  mon_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/pfd_divider_core_chk.sv
module pfd_divider_core_chk #(
    parameter int ABL_CYC = 3
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_sel,
    input logic       pump_up,
    input logic       pump_dn,
    input logic       pump_oe,
    input logic       mon_out
);
    localparam int RW = $clog2(ABL_CYC + 2);
    logic [RW-1:0] both_run;

    always_ff @(posedge clk) begin
        if (rst)                              both_run <= '0;
        else if (pump_up && pump_dn) begin
            if (both_run != RW'(ABL_CYC + 1)) both_run <= both_run + 1'b1;
        end else                              both_run <= '0;
    end

    p_oe_decode_r4: assert property (@(posedge clk) disable iff (rst)
        pump_oe == (mode_sel != 2'b01));

    p_open_loop_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b01) |-> (!pump_up && !pump_dn));

    p_overlap_bound_r7: assert property (@(posedge clk) disable iff (rst)
        (pump_up && pump_dn) |-> (both_run < RW'(ABL_CYC)));

    p_mon_high_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b00) |-> mon_out);

    p_mon_low_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b11) |-> !mon_out);
endmodule

bind pfd_divider_core pfd_divider_core_chk #(.ABL_CYC(ABL_CYC)) u_chk (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .pump_up(pump_up),
    .pump_dn(pump_dn), .pump_oe(pump_oe), .mon_out(mon_out)
);

// File: tb/tb_pfd_divider_core.sv
module tb_pfd_divider_core;
    localparam int ABL = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rf_in = 1'b0;
    logic       ref_in = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic [1:0] mode_sel = 2'b00;
    logic       pump_up, pump_dn, pump_oe, mon_out;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    pfd_divider_core dut (
        .clk(clk), .rst(rst), .rf_in(rf_in), .ref_in(ref_in),
        .div_sel(div_sel), .mode_sel(mode_sel),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_oe(pump_oe), .mon_out(mon_out)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side: queue the expected item.
    task automatic expect_val(input string tag, input int v);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // Monitor side: pop and compare with what the design produced.
    task automatic observe(input int act);
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (act != e) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", t, act, e);
        end
    endtask

    task automatic do_reset(input logic [1:0] m, input logic [1:0] s);
        mode_sel = m;
        div_sel  = s;
        rf_in    = 1'b0;
        ref_in   = 1'b0;
        rst      = 1'b1;
        tick(3);
        rst      = 1'b0;
        tick(2);
    endtask

    task automatic rf_pulses(input int n);
        repeat (n) begin
            rf_in = 1'b1; tick(2);
            rf_in = 1'b0; tick(2);
        end
    endtask

    task automatic ref_pulses(input int n, input int half);
        repeat (n) begin
            ref_in = 1'b1; tick(half);
            ref_in = 1'b0; tick(half);
        end
    endtask

    task automatic measure_mon(input int limit, output int p);
        logic pv;
        int   rises;
        int   t0;
        pv    = mon_out;
        rises = 0;
        t0    = 0;
        p     = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (mon_out && !pv) begin
                rises++;
                if (rises == 2) t0 = i;
                if (rises == 3) begin
                    p = i - t0;
                    break;
                end
            end
            pv = mon_out;
        end
    endtask

    task automatic count_overlap(input int window, output int both_cnt);
        both_cnt = 0;
        for (int i = 0; i < window; i++) begin
            @(negedge clk);
            if (pump_up && pump_dn) both_cnt++;
        end
    endtask

    initial begin
        #1_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int p;
        int ov;

        // R10: reset state
        do_reset(2'b00, 2'b00);
        expect_val("R10 pump_up after reset", 0); observe(pump_up);
        expect_val("R10 pump_dn after reset", 0); observe(pump_dn);
        expect_val("R4 pump_oe mode 00", 1);      observe(pump_oe);
        expect_val("R5 mon high mode 00", 1);     observe(mon_out);
        mode_sel = 2'b01; tick(1);
        expect_val("R10 ref divider low after reset", 0); observe(mon_out);
        expect_val("R4 pump_oe mode 01", 0);              observe(pump_oe);
        mode_sel = 2'b11; tick(1);
        expect_val("R5 mon low mode 11", 0);  observe(mon_out);
        expect_val("R4 pump_oe mode 11", 1);  observe(pump_oe);

        // R1: feedback ratios, rf period 4 cycles
        for (int s = 0; s < 4; s++) begin
            do_reset(2'b10, 2'(s));
            expect_val($sformatf("R1 fb period sel %0d", s), 4 * (8 << s));
            fork
                rf_pulses(3 * (8 << s) + 4);
                measure_mon(20000, p);
            join
            observe(p);
        end

        // R2: reference ratio, ref period 6 cycles
        do_reset(2'b01, 2'b00);
        expect_val("R2 ref period", 12);
        fork
            ref_pulses(10, 3);
            measure_mon(2000, p);
        join
        observe(p);

        // R3: select change waits for the terminal count
        do_reset(2'b10, 2'b00);
        rf_pulses(2);
        div_sel = 2'b01;
        rf_pulses(2); tick(2);
        expect_val("R3 old ratio completes", 1); observe(mon_out);
        rf_pulses(7); tick(2);
        expect_val("R3 new ratio not yet done", 1); observe(mon_out);
        rf_pulses(1); tick(2);
        expect_val("R3 new ratio toggle at 8", 0); observe(mon_out);

        // R6/R7: ref first, then feedback
        do_reset(2'b00, 2'b00);
        ref_pulses(1, 2); tick(6);
        expect_val("R6 up held alone", 1);  observe(pump_up);
        expect_val("R6 dn idle", 0);        observe(pump_dn);
        tick(20);
        expect_val("R6 up still held", 1);  observe(pump_up);
        fork
            rf_pulses(4);
            count_overlap(40, ov);
        join
        expect_val("R7 overlap length", ABL); observe(ov);
        expect_val("R7 up cleared", 0);       observe(pump_up);
        expect_val("R7 dn cleared", 0);       observe(pump_dn);

        // R6: feedback first
        do_reset(2'b00, 2'b00);
        rf_pulses(4); tick(6);
        expect_val("R6 dn held alone", 1);  observe(pump_dn);
        expect_val("R6 up idle", 0);        observe(pump_up);

        // R8: inverted polarity
        do_reset(2'b11, 2'b00);
        ref_pulses(1, 2); tick(6);
        expect_val("R8 ref edge drives dn", 1); observe(pump_dn);
        expect_val("R8 up idle", 0);            observe(pump_up);
        fork
            rf_pulses(4);
            count_overlap(40, ov);
        join
        expect_val("R8 R7 inverted overlap", ABL); observe(ov);

        // R9: gated outputs, state kept
        do_reset(2'b01, 2'b00);
        ref_pulses(1, 2); tick(6);
        expect_val("R9 up gated", 0); observe(pump_up);
        expect_val("R9 dn gated", 0); observe(pump_dn);
        mode_sel = 2'b00; tick(2);
        expect_val("R9 kept flag shows", 1); observe(pump_up);

        // R10: reset clears a set flag
        rst = 1'b1; tick(2); rst = 1'b0; tick(2);
        expect_val("R10 flag cleared by reset", 0); observe(pump_up);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule